// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Change Interrupt

This block manages a bank of general-purpose pins for a host that reaches it through a simple register bus carrying an address, write data, a write strobe and a read strobe. Software picks, pin by pin, whether a pin drives or listens. It sets the level on driven pins and reads back the synchronised level of every pin. Any level change on a listening pin is recorded in a sticky status register.

The status register collects changes regardless of the enable mask, and reading it clears it. The interrupt line is the OR of the status bits that the mask enables. A control register gates that line, chooses whether it is active high or active low, carries a shutdown request for the bus interface, and issues a soft reset that returns every register to its default.

Register reads are combinational from the current address. Side effects of a read or a write take place at the rising clock edge on which the strobe is high.

Top module: `gpx_ctrl`

## Requirements
- R1: The direction register at address 0x12 drives `pin_oe` bit for bit (1 = drive, 0 = listen) and reads back as written; it is 0 after reset.
- R2: The output-level register at address 0x11 drives `pin_out` bit for bit and reads back as written.
- R3: Address 0x10 returns `pin_in` through a two-flop synchroniser, so a pin change is visible two clock edges after it is applied; writes to 0x10 change nothing.
- R4: A rising or falling change on a pin whose direction bit is 0 sets that pin's bit of the status register at 0x09 on the third clock edge after the change; changes on driven pins set nothing, and set bits stay set until cleared.
- R5: Status bits are set whether or not the matching bit of the enable mask at 0x08 is 1.
- R6: A read strobe at 0x09 clears all status bits at that edge, except a change detected at the same edge, which stays set; writes to 0x09 change nothing.
- R7: The control register at 0x04 uses bit 0 as interrupt enable and bit 1 as polarity. The interrupt is active when enable is 1 and any status bit is 1 with its mask bit also 1. `irq_line` equals the active state when polarity is 1 and its inverse when polarity is 0, so a disabled output sits at the inactive level.
- R8: Control bit 2 drives `shdn_req`; control bits 6:0 read back as written, and bit 7 reads 0.
- R9: Writing control with bit 7 set clears the direction, output-level, mask, status and control registers at that edge.
- R10: The synchronous active-high `rst` clears every register, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (clears status when it addresses 0x09) |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin drive enable |
| pin_out | output | 8 | Per-pin drive level |
| irq_line | output | 1 | Interrupt line, programmable polarity |
| shdn_req | output | 1 | Shutdown request to the bus interface |

## Verification
The assertions assume that `rst` is high on the first clock edge, so the synchroniser flops hold defined values before any edge comparison. They also assume that the bus never strobes a soft reset and a status read in the same cycle, which the single shared address makes impossible. The bench changes `pin_in`, the address and the strobes only just after falling edges, so every sampled input is stable at the rising edge. It aims one pin change so that it is detected exactly on the edge of a status read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int unsigned PINS   = 8;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 8'h04;
    localparam logic [ADDR_W-1:0] A_MASK = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h09;
    localparam logic [ADDR_W-1:0] A_MON  = 8'h10;
    localparam logic [ADDR_W-1:0] A_OUT  = 8'h11;
    localparam logic [ADDR_W-1:0] A_DIR  = 8'h12;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_POL_BIT  = 1;
    localparam int unsigned CTRL_SHDN_BIT = 2;
    localparam int unsigned CTRL_SRST_BIT = 7;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_MASK, SEL_STAT, SEL_MON, SEL_OUT, SEL_DIR
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            A_CTRL:  return SEL_CTRL;
            A_MASK:  return SEL_MASK;
            A_STAT:  return SEL_STAT;
            A_MON:   return SEL_MON;
            A_OUT:   return SEL_OUT;
            A_DIR:   return SEL_DIR;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic line_level(input logic active, input logic pol);
        return pol ? active : ~active;
    endfunction
endpackage

// File: rtl/gpx_pin_sync.sv
module gpx_pin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] dir,
    output logic [W-1:0] mon,
    output logic [W-1:0] edge_vec
);
    logic [W-1:0] st1, st2, st3;

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                st1[i] <= 1'b0;
                st2[i] <= 1'b0;
                st3[i] <= 1'b0;
            end else begin
                st1[i] <= pin_in[i];
                st2[i] <= st1[i];
                st3[i] <= st2[i];
            end
        end
        assign edge_vec[i] = (st2[i] ^ st3[i]) & ~dir[i];
    end

    assign mon = st2;
endmodule

// File: rtl/gpx_irq_unit.sv
module gpx_irq_unit #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         srst,
    input  logic         clr,
    input  logic [W-1:0] edge_vec,
    input  logic [W-1:0] mask,
    input  logic         en,
    input  logic         pol,
    output logic [W-1:0] status,
    output logic         irq_line
);
    import gpx_pkg::*;

    logic [W-1:0] keep;
    logic         active;

    assign keep = clr ? '0 : status;

    always_ff @(posedge clk) begin
        if (rst || srst) status <= '0;
        else             status <= keep | edge_vec;
    end

    assign active   = en && (|(status & mask));
    assign irq_line = line_level(active, pol);

    // R4: set bits survive until a read or a reset
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !srst) |=> ((status & $past(status)) == $past(status)));

    // R5: a detected change lands whatever the mask holds
    p_set_any_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (!srst) |=> ((status & $past(edge_vec)) == $past(edge_vec)));

    // R6: after a read only changes caught at that edge remain
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && !srst) |=> (status == $past(edge_vec)));

    // R7: a disabled output stays at the inactive level
    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!en) |-> (irq_line != pol));
endmodule

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
    import gpx_pkg::*;
#(
    parameter int unsigned PIN_W = PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_out,
    output logic              irq_line,
    output logic              shdn_req
);
    localparam logic [PIN_W-1:0] CTRL_KEEP = ~(PIN_W'(1) << CTRL_SRST_BIT);

    reg_sel_e         sel;
    logic [PIN_W-1:0] dir_q, out_q, mask_q, ctrl_q;
    logic [PIN_W-1:0] mon, edge_vec, status;
    logic             soft_rst, stat_clr;

    assign sel      = decode(bus_addr);
    assign soft_rst = bus_we && (sel == SEL_CTRL) && bus_wdata[CTRL_SRST_BIT];
    assign stat_clr = bus_re && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_OUT:  out_q  <= bus_wdata;
                SEL_MASK: mask_q <= bus_wdata;
                SEL_CTRL: ctrl_q <= bus_wdata & CTRL_KEEP;
                default:  ;
            endcase
        end
    end

    gpx_pin_sync #(.W(PIN_W)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .dir      (dir_q),
        .mon      (mon),
        .edge_vec (edge_vec)
    );

    gpx_irq_unit #(.W(PIN_W)) irq_i (
        .clk      (clk),
        .rst      (rst),
        .srst     (soft_rst),
        .clr      (stat_clr),
        .edge_vec (edge_vec),
        .mask     (mask_q),
        .en       (ctrl_q[CTRL_EN_BIT]),
        .pol      (ctrl_q[CTRL_POL_BIT]),
        .status   (status),
        .irq_line (irq_line)
    );

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_MASK: bus_rdata = mask_q;
            SEL_STAT: bus_rdata = status;
            SEL_MON:  bus_rdata = mon;
            SEL_OUT:  bus_rdata = out_q;
            SEL_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe   = dir_q;
    assign pin_out  = out_q;
    assign shdn_req = ctrl_q[CTRL_SHDN_BIT];

    // R9: soft reset leaves pins listening and the line idle-high
    p_soft_defaults_r9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (pin_oe == '0 && pin_out == '0 && irq_line && !shdn_req));

    // R1: a write to direction shows on the pins one edge later
    p_dir_write_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_DIR) |=> (pin_oe == $past(bus_wdata)));
endmodule

// File: tb/gpx_ctrl_tb_top.sv
module gpx_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata, pin_oe, pin_out;
    logic       irq_line, shdn_req;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #5 clk = ~clk;

    gpx_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .irq_line(irq_line), .shdn_req(shdn_req)
    );

    // behavioural reference
    logic [7:0] m_dir, m_out, m_mask, m_stat, m_ctrl;
    logic [7:0] hist[$];

    always @(posedge clk) begin
        logic [7:0] chg;
        started <= 1'b1;
        if (rst) begin
            m_dir = 0; m_out = 0; m_mask = 0; m_stat = 0; m_ctrl = 0;
            hist = '{8'h00, 8'h00, 8'h00};
        end else begin
            chg = (hist[1] ^ hist[2]) & ~m_dir;
            if (bus_we && bus_addr == 8'h04 && bus_wdata[7]) begin
                m_dir = 0; m_out = 0; m_mask = 0; m_stat = 0; m_ctrl = 0;
            end else begin
                if (bus_re && bus_addr == 8'h09) m_stat = 0;
                m_stat = m_stat | chg;
                if (bus_we) begin
                    if (bus_addr == 8'h12) m_dir  = bus_wdata;
                    if (bus_addr == 8'h11) m_out  = bus_wdata;
                    if (bus_addr == 8'h08) m_mask = bus_wdata;
                    if (bus_addr == 8'h04) m_ctrl = bus_wdata & 8'h7F;
                end
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [7:0] m_rdata(input logic [7:0] a);
        case (a)
            8'h04: return m_ctrl;
            8'h08: return m_mask;
            8'h09: return m_stat;
            8'h10: return hist[1];
            8'h11: return m_out;
            8'h12: return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rtag(input logic [7:0] a);
        case (a)
            8'h04: return "R8";
            8'h08: return "R5";
            8'h09: return "R4";
            8'h10: return "R3";
            8'h11: return "R2";
            8'h12: return "R1";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always begin
        logic m_act;
        @(negedge clk);
        #2;
        if (started) begin
            m_act = m_ctrl[0] && (|(m_stat & m_mask));
            chk("R1 pin_oe", pin_oe, m_dir);
            chk("R2 pin_out", pin_out, m_out);
            chk("R7 irq_line", {7'b0, irq_line}, {7'b0, m_ctrl[1] ? m_act : !m_act});
            chk("R8 shdn_req", {7'b0, shdn_req}, {7'b0, m_ctrl[2]});
            chk({rtag(bus_addr), " rdata"}, bus_rdata, m_rdata(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1; bus_re = 0;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic peek(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 0; bus_re = 0;
        #3 chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R10 reset state
        peek("R10 ctrl after reset", 8'h04, 8'h00);
        peek("R10 mask after reset", 8'h08, 8'h00);
        peek("R10 status after reset", 8'h09, 8'h00);
        peek("R1 direction after reset", 8'h12, 8'h00);
        chk("R7 idle line after reset", {7'b0, irq_line}, 8'h01);
        // R1 R2
        wr(8'h12, 8'hF0);
        wr(8'h11, 8'hA5);
        chk("R1 pin_oe", pin_oe, 8'hF0);
        chk("R2 pin_out", pin_out, 8'hA5);
        peek("R2 readback", 8'h11, 8'hA5);
        // R3 R4 R5: bit 7 is driven, bits 3:0 listen, mask is zero
        @(negedge clk); pin_in = 8'h8F;
        repeat (3) @(negedge clk);
        peek("R3 monitor", 8'h10, 8'h8F);
        peek("R4 R5 status unmasked", 8'h09, 8'h0F);
        wr(8'h10, 8'hFF);
        peek("R3 monitor write ignored", 8'h10, 8'h8F);
        wr(8'h09, 8'h00);
        peek("R6 status write ignored", 8'h09, 8'h0F);
        // R7
        wr(8'h08, 8'h01);
        wr(8'h04, 8'h03);
        chk("R7 active high", {7'b0, irq_line}, 8'h01);
        wr(8'h04, 8'h01);
        chk("R7 active low", {7'b0, irq_line}, 8'h00);
        wr(8'h04, 8'h00);
        chk("R7 disabled idle", {7'b0, irq_line}, 8'h01);
        // R6 clear on read
        @(negedge clk); bus_addr = 8'h09; bus_re = 1;
        #3 chk("R6 read value", bus_rdata, 8'h0F);
        @(negedge clk); bus_re = 0;
        #3 chk("R6 cleared", bus_rdata, 8'h00);
        // R6 change caught on the read edge survives
        @(negedge clk); pin_in = 8'h8E;
        @(negedge clk);
        @(negedge clk); bus_addr = 8'h09; bus_re = 1;
        @(negedge clk); bus_re = 0;
        #3 chk("R6 same-edge change kept", bus_rdata, 8'h01);
        // R8
        wr(8'h04, 8'h7C);
        chk("R8 shdn_req", {7'b0, shdn_req}, 8'h01);
        peek("R8 ctrl readback", 8'h04, 8'h7C);
        // R9
        wr(8'h08, 8'hFF);
        wr(8'h04, 8'h83);
        peek("R9 ctrl cleared", 8'h04, 8'h00);
        peek("R9 mask cleared", 8'h08, 8'h00);
        peek("R9 status cleared", 8'h09, 8'h00);
        chk("R9 pin_oe cleared", pin_oe, 8'h00);
        chk("R9 pin_out cleared", pin_out, 8'h00);
        // R10 unmapped
        wr(8'h05, 8'hFF);
        peek("R10 unmapped 0x05", 8'h05, 8'h00);
        peek("R10 unmapped 0x13", 8'h13, 8'h00);
        // mixed traffic checked by the reference each cycle
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            @(negedge clk);
            r = $urandom;
            if (r[2:0] == 0) pin_in = 8'($urandom);
            bus_we = 0; bus_re = 0;
            case (r[6:4])
                0: begin bus_we = 1; bus_addr = 8'h12; bus_wdata = 8'($urandom); end
                1: begin bus_we = 1; bus_addr = 8'h08; bus_wdata = 8'($urandom); end
                2: begin bus_we = 1; bus_addr = 8'h04;
                         bus_wdata = (r[15:8] == 0) ? 8'h80 : 8'($urandom) & 8'h7F; end
                3: begin bus_re = 1; bus_addr = 8'h09; end
                4: begin bus_we = 1; bus_addr = 8'h11; bus_wdata = 8'($urandom); end
                default: bus_addr = 8'($urandom);
            endcase
        end
        @(negedge clk); bus_we = 0; bus_re = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule